// File: doc/BRIEF.md
# Single-Cycle Recursive Control Law

This block evaluates a fixed-point, IIR-like control law for one sample stream, running directly on the converter sample clock. For every accepted sample it forms the result as K1 times the sum of the current and previous input samples, plus K2 times the current state sample, plus the result from the previous sample. The result is saturated to the 16-bit signed range and drives the output converter.

Only the boundaries are registered. A capture stage takes in the input sample, the state sample and both coefficients. An output stage holds the saturated result, and that same register feeds back as the previous-output term. Everything between the two stages is combinational: the pair adder, two full-precision multipliers, the scaling shifts, a wide accumulator and the clamp. A strobe qualifies each sample. When the strobe is low, the delay and feedback registers keep their values.

Top module: `ctlrec_top`

## Requirements
- R1: For each accepted sample the output is sat(floor(K1*(x_now + x_prev) / 2^14) + floor(K2*s_now / 2^14) + y_prev). x_now and s_now are the current input and state samples, x_prev is the input of the previous accepted sample, and y_prev is the previous output.
- R2: x_prev is the input sample of the previous accepted sample. It is zero after reset, and it is updated only when a sample is accepted.
- R3: y_prev is the value held in the output register, which is the result of the previous accepted sample.
- R4: K1 and K2 are 16-bit signed values in Q1.14 format, so 16384 means 1.0. Each product is formed at full width and then shifted right arithmetically by 14 bits, which rounds toward minus infinity. The terms are summed in an accumulator wide enough that the sum cannot overflow.
- R5: The sum is clamped to the range -32768 to 32767 before it is stored. A result above the range gives 32767 and a result below it gives -32768.
- R6: A sample presented with `smp_vld` high at clock edge n appears on `dac_out` after edge n+1. Consecutive samples may be presented on consecutive edges.
- R7: `dac_vld` is high for exactly one cycle per accepted sample, aligned with the new `dac_out` value. It is low otherwise.
- R8: While `smp_vld` is low, the input delay, the output feedback and `dac_out` hold their values. The sample, state and coefficient inputs have no effect during that time.
- R9: A synchronous active-high `rst` clears the input delay, the output register and both valid flags to zero. `rst` takes priority over `smp_vld`.
- R10: K1 and K2 are captured together with each accepted sample, so every sample uses the coefficients presented with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Qualifies the sample, state and coefficient inputs |
| smp_in | input | 16 | Signed input sample |
| st_in | input | 16 | Signed state sample |
| k1_in | input | 16 | Signed Q1.14 coefficient on the input pair |
| k2_in | input | 16 | Signed Q1.14 coefficient on the state sample |
| dac_vld | output | 1 | High for one cycle with each new result |
| dac_out | output | 16 | Saturated signed result |

## Verification
The assertions assume that `rst` is a clean synchronous level and that `smp_vld` is a known 0 or 1 at every edge. The hold properties rely on the capture stage being the only route by which data enters. The stimulus drives all inputs on the falling edge and only changes `smp_vld` there. It also drives deliberately junk sample and coefficient values while the strobe is low, so the hold properties are exercised against changing data. Saturation is reached by running the feedback loop past both rails, which stresses the clamp under conditions the assertions do not restrict.

// File: rtl/ctlrec_pkg.sv
package ctlrec_pkg;
    // default widths of the control law
    localparam int SMP_W_DEF  = 16;
    localparam int COEF_W_DEF = 16;
    localparam int FRAC_DEF   = 14;
endpackage

// File: rtl/ctlrec_law.sv
module ctlrec_law #(
    parameter int SMP_W  = 16,
    parameter int COEF_W = 16,
    parameter int FRAC   = 14,
    parameter int ACC_W  = SMP_W + COEF_W + 3
) (
    input  logic signed [SMP_W-1:0]  x_now,
    input  logic signed [SMP_W-1:0]  x_prev,
    input  logic signed [SMP_W-1:0]  st_now,
    input  logic signed [COEF_W-1:0] k1,
    input  logic signed [COEF_W-1:0] k2,
    input  logic signed [SMP_W-1:0]  y_prev,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PAIR_W = SMP_W + 1;
    localparam int P1_W   = PAIR_W + COEF_W;
    localparam int P2_W   = SMP_W + COEF_W;

    logic signed [PAIR_W-1:0] pair;
    logic signed [P1_W-1:0]   prod1, term1;
    logic signed [P2_W-1:0]   prod2, term2;

    always_comb begin
        pair  = {x_now[SMP_W-1], x_now} + {x_prev[SMP_W-1], x_prev};
        prod1 = pair * k1;
        prod2 = st_now * k2;
        term1 = prod1 >>> FRAC;
        term2 = prod2 >>> FRAC;
        acc   = {{(ACC_W-P1_W){term1[P1_W-1]}}, term1}
              + {{(ACC_W-P2_W){term2[P2_W-1]}}, term2}
              + {{(ACC_W-SMP_W){y_prev[SMP_W-1]}}, y_prev};
    end
endmodule

// File: rtl/ctlrec_sat.sv
module ctlrec_sat #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 35
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [SMP_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO = ~HI;

    always_comb begin
        if (acc > HI)      y = HI[SMP_W-1:0];
        else if (acc < LO) y = LO[SMP_W-1:0];
        else               y = acc[SMP_W-1:0];
    end
endmodule

// File: rtl/ctlrec_top.sv
module ctlrec_top
    import ctlrec_pkg::*;
#(
    parameter int SMP_W  = SMP_W_DEF,
    parameter int COEF_W = COEF_W_DEF,
    parameter int FRAC   = FRAC_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic signed [SMP_W-1:0]  smp_in,
    input  logic signed [SMP_W-1:0]  st_in,
    input  logic signed [COEF_W-1:0] k1_in,
    input  logic signed [COEF_W-1:0] k2_in,
    output logic                     dac_vld,
    output logic signed [SMP_W-1:0]  dac_out
);
    localparam int ACC_W = SMP_W + COEF_W + 3;

    typedef struct packed {
        logic                     cap_v;
        logic signed [SMP_W-1:0]  xn;
        logic signed [SMP_W-1:0]  xp;
        logic signed [SMP_W-1:0]  st;
        logic signed [COEF_W-1:0] k1;
        logic signed [COEF_W-1:0] k2;
        logic                     out_v;
        logic signed [SMP_W-1:0]  y;
    } regs_t;

    regs_t r_d, r_q;
    logic signed [ACC_W-1:0] acc_w;
    logic signed [SMP_W-1:0] y_sat;

    ctlrec_law #(
        .SMP_W (SMP_W),
        .COEF_W(COEF_W),
        .FRAC  (FRAC),
        .ACC_W (ACC_W)
    ) u_law (
        .x_now (r_q.xn),
        .x_prev(r_q.xp),
        .st_now(r_q.st),
        .k1    (r_q.k1),
        .k2    (r_q.k2),
        .y_prev(r_q.y),
        .acc   (acc_w)
    );

    ctlrec_sat #(
        .SMP_W(SMP_W),
        .ACC_W(ACC_W)
    ) u_sat (
        .acc(acc_w),
        .y  (y_sat)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d = '0;
        end else begin
            r_d.cap_v = smp_vld;
            if (smp_vld) begin
                r_d.xp = r_q.xn;
                r_d.xn = smp_in;
                r_d.st = st_in;
                r_d.k1 = k1_in;
                r_d.k2 = k2_in;
            end
            r_d.out_v = r_q.cap_v;
            if (r_q.cap_v) begin
                r_d.y = y_sat;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign dac_vld = r_q.out_v;
    assign dac_out = r_q.y;

    // R2
    prev_delay_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> (r_q.xp == $past(r_q.xn)));

    // R8
    hold_input_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(r_q.xn) && $stable(r_q.xp)));

    // R8
    hold_feedback_chk: assert property (@(posedge clk) disable iff (rst)
        !r_q.cap_v |=> $stable(dac_out));

    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.cap_v |=> dac_vld);

    // R7
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !r_q.cap_v |=> !dac_vld);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> r_q.cap_v);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_out == '0 && !dac_vld && r_q.xp == '0 && !r_q.cap_v));
endmodule

// File: tb/tb_ctlrec_top.sv
`timescale 1ns/1ps
module tb_ctlrec_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [15:0] smp_in = '0, st_in = '0, k1_in = '0, k2_in = '0;
    logic dac_vld;
    logic signed [15:0] dac_out;

    int n_chk = 0;
    int n_fail = 0;
    int m_xp = 0;
    int m_y = 0;

    always #5 clk = ~clk;

    ctlrec_top dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
        .st_in(st_in), .k1_in(k1_in), .k2_in(k2_in),
        .dac_vld(dac_vld), .dac_out(dac_out)
    );

    localparam int NV = 10;
    localparam int VX  [NV] = '{1000, -2500, 12345, -7, 32767, -32768, 4321, 0, -15000, 777};
    localparam int VS  [NV] = '{200, -300, 4000, 3, -32768, 32767, -1, 5000, 123, -9999};
    localparam int VK1 [NV] = '{8192, 8192, -4096, 16383, 1000, -16384, 3, 8192, 12000, -32768};
    localparam int VK2 [NV] = '{-4096, 2048, 16384, -1, 500, -20000, -5, 0, -7000, 32767};

    function automatic int model(int x, int xp, int s, int k1, int k2, int y);
        longint a, b, t;
        a = (longint'(k1) * longint'(x + xp)) >>> 14;
        b = (longint'(k2) * longint'(s)) >>> 14;
        t = a + b + longint'(y);
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return int'(t);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one isolated sample: drive, gap, check
    task automatic send(input int x, input int s, input int k1, input int k2, input string req);
        int e;
        e = model(x, m_xp, s, k1, k2, m_y);
        @(negedge clk);
        smp_vld = 1'b1; smp_in = 16'(x); st_in = 16'(s); k1_in = 16'(k1); k2_in = 16'(k2);
        @(negedge clk);
        smp_vld = 1'b0; smp_in = 16'h5A5A; k1_in = 16'h7FFF;
        chk(dac_vld == 1'b0, "R6 early", int'(dac_vld), 0);
        @(negedge clk);
        chk(dac_vld == 1'b1, "R7 valid", int'(dac_vld), 1);
        chk(int'(dac_out) == e, req, int'(dac_out), e);
        m_xp = x;
        m_y = e;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dac_out == 0, "R9 reset out", int'(dac_out), 0);
        chk(dac_vld == 0, "R9 reset vld", int'(dac_vld), 0);
        rst = 1'b0;

        // R1 R3 R4 R10: table walk through the recurrence
        for (int i = 0; i < NV; i++) begin
            send(VX[i], VS[i], VK1[i], VK2[i], "R1 table");
        end

        // R8: strobe low with junk inputs, output and delay must hold
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            smp_in = 16'(i * 911 - 3000); st_in = 16'(i * 77); k1_in = 16'(-i * 1234); k2_in = 16'(i * 999);
            chk(int'(dac_out) == m_y, "R8 hold out", int'(dac_out), m_y);
            chk(dac_vld == 1'b0, "R8 vld low", int'(dac_vld), 0);
        end
        send(-1234, 5678, 4096, -8192, "R8 prev kept");

        // R6 R7: back-to-back samples on consecutive edges
        begin
            int ex[4];
            int sx[4] = '{300, -450, 9000, -12};
            int ss[4] = '{-100, 250, 7, 4096};
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (i >= 2) begin
                    chk(dac_vld == 1'b1, "R7 stream vld", int'(dac_vld), 1);
                    chk(int'(dac_out) == ex[i-2], "R6 stream data", int'(dac_out), ex[i-2]);
                end
                if (i < 4) begin
                    ex[i] = model(sx[i], m_xp, ss[i], 6000 + i, -3000 - i, m_y);
                    m_xp = sx[i];
                    m_y = ex[i];
                    smp_vld = 1'b1; smp_in = 16'(sx[i]); st_in = 16'(ss[i]);
                    k1_in = 16'(6000 + i); k2_in = 16'(-3000 - i);
                end else begin
                    smp_vld = 1'b0;
                end
            end
            @(negedge clk);
            chk(dac_vld == 1'b0, "R7 stream end", int'(dac_vld), 0);
        end

        // R9: reset with a valid sample presented
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b1; smp_in = 16'sd9999;
        @(negedge clk);
        chk(dac_out == 0, "R9 clear out", int'(dac_out), 0);
        chk(dac_vld == 0, "R9 clear vld", int'(dac_vld), 0);
        rst = 1'b0; smp_vld = 1'b0;
        m_xp = 0; m_y = 0;
        send(100, 0, 16384, 0, "R9 prev zero");

        // R5: positive rail
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_xp = 0; m_y = 0;
        send(30000, 0, 16384, 0, "R5 ramp");
        send(30000, 0, 16384, 0, "R5 pos");
        chk(dac_out == 16'sd32767, "R5 pos rail", int'(dac_out), 32767);
        send(0, 0, 0, 0, "R5 hold rail");
        chk(dac_out == 16'sd32767, "R3 rail feedback", int'(dac_out), 32767);

        // R5: negative rail
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_xp = 0; m_y = 0;
        send(-32768, 0, 16384, 0, "R5 ramp neg");
        send(-32768, 0, 16384, 0, "R5 neg");
        chk(dac_out == -16'sd32768, "R5 neg rail", int'(dac_out), -32768);

        // R4: floor rounding of negative products
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_xp = 0; m_y = 0;
        send(0, -1, 0, 1, "R4 floor");
        chk(dac_out == -16'sd1, "R4 floor value", int'(dac_out), -1);

        finish_run();
    end
endmodule